// File: doc/BRIEF.md
# Prescaler-Extended PWM Timer

One timer channel that turns a down-counter into a pulse-width-modulated output. The counter is 24 bits wide. Its low 16 bits come from a load register and its high 8 bits come from a prescale register. The duty threshold is split the same way, across a match register and a prescale-match register. A small register port configures the channel:

- the mode word, which must select PWM before the counter will move;
- the enable;
- the output polarity;
- the choice of waveform edge that raises the capture-event flag.

Software programs the mode, period, threshold, polarity and edge choice while the channel is stopped, then sets the enable. After that the counter runs without end. The period can be changed at any time, and the change is applied at the next reload. The threshold can also be changed at any time, and it is compared from the next cycle onward. The event flag is sticky, is cleared by writing one, and reaches the `irq` pin only through a mask bit. The register port is a plain single-cycle write strobe with a combinational read mux. It has no valid/ready handshake, because no data stream crosses the block.

Top module: `pwm24_timer`

## Requirements
- R1: After reset, `pwm_out` and `irq` are 0 and every register reads 0.
- R2: While running, the counter reloads with P = {prescale[7:0] (addr 4), load[15:0] (addr 2)} when it reaches 0, and otherwise decrements by one. The reload happens on the first clock after the channel starts running, so the waveform repeats every P+1 cycles.
- R3: With threshold M = {prescale-match[7:0] (addr 5), match[15:0] (addr 3)} and M < P, the internal waveform rises at reload and is high for P-M cycles, then low for M+1 cycles. If M >= P, it stays high for the whole period.
- R4: The channel runs only when the enable bit is set and mode[3:0] (addr 0) equals 4'b1010: alternate-select bit 3 = 1, capture bit 2 = 0 (edge-count), field 1:0 = 2 (periodic). Otherwise the counter is held at 0, the internal waveform is held low, and `pwm_out` shows the idle level.
- R5: Control register (addr 1) bit 6 inverts `pwm_out` relative to the internal waveform. With the default channel-A layout, bit 0 is the enable and bits 3:2 are the event code. Channel B (CHANNEL=1) uses bits 14, 8 and 11:10 instead.
- R6: A write to the load or prescale register while the channel runs does not change the period in progress. It takes effect at the next reload.
- R7: A write to the match or prescale-match register is compared from the next cycle. This includes the period already in progress.
- R8: Event code 0 fires on a rising edge of the internal waveform, code 1 on a falling edge, and code 3 on either edge. Edges count only while the channel runs. When the output is inverted, code 0 therefore responds to a falling edge of `pwm_out` and code 1 to a rising edge.
- R9: Event code 2 never sets the event flag.
- R10: The event flag sets only while the interrupt-enable bit (mode bit 9) is 1. `irq` is the flag ANDed with mask bit 0 (addr 6).
- R11: The event flag (addr 7, bit 0) stays set until a write to addr 7 with bit 0 = 1. A write with bit 0 = 0 leaves it set. If a new event and a clear arrive in the same cycle, the event wins.
- R12: Writes to the mode register (addr 0) are ignored while the enable bit is set.
- R13: Each register reads back its written value. Only the implemented bits return data: mode bits 9 and 3:0, the three control fields, 16 bits each of load and match, 8 bits each of the two prescale registers, and bit 0 of mask and status. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 3 | Register index for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | PWM pin after polarity |
| irq | output | 1 | Masked capture-event flag |

## Verification
The in-design assertions assume the reset is held long enough to clear every register. They also assume `reg_addr` and `reg_wdata` are stable whenever `reg_wr` is high, and that the period is rewritten only through the registers, so the counter's single-step decrement and its reload value can be related cycle by cycle. The stimulus stops the channel before reprogramming it and clears the event flag after each stop. It changes only load or match while the channel runs, at a cycle chosen so that the old and new behaviour give visibly different waveforms.

// File: rtl/pwm24_pkg.sv
package pwm24_pkg;
  localparam int REG_AW = 3;
  localparam int DW     = 16;
  localparam int LO_W   = 16;
  localparam int PRE_W  = 8;
  localparam int CNT_W  = LO_W + PRE_W;
  localparam int MODE_W = 4;
  localparam int IE_BIT = 9;

  localparam logic [1:0] MODE_PERIODIC = 2'd2;

  typedef enum logic [REG_AW-1:0] {
    A_MODE   = 3'd0,
    A_CTRL   = 3'd1,
    A_LOAD   = 3'd2,
    A_MATCH  = 3'd3,
    A_PRE    = 3'd4,
    A_PMATCH = 3'd5,
    A_MASK   = 3'd6,
    A_STAT   = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    EV_POS  = 2'd0,
    EV_NEG  = 2'd1,
    EV_NONE = 2'd2,
    EV_BOTH = 2'd3
  } evt_sel_e;

  typedef struct packed {
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] match;
    logic             run;
    logic             invert;
    evt_sel_e         evt;
    logic             ie;
    logic             mask;
  } chan_cfg_t;
endpackage

// File: rtl/pwm24_regs.sv
module pwm24_regs
  import pwm24_pkg::*;
#(
  parameter int CHANNEL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              stat,
  output logic [DW-1:0]     rdata,
  output chan_cfg_t         cfg,
  output logic              stat_clr
);
  // control-register layout picked by the channel index
  localparam int EN_BIT  = (CHANNEL == 0) ? 0 : 8;
  localparam int EVT_LSB = (CHANNEL == 0) ? 2 : 10;
  localparam int LVL_BIT = (CHANNEL == 0) ? 6 : 14;

  logic [MODE_W-1:0] mode_q;
  logic              ie_q;
  logic              en_q;
  logic              lvl_q;
  logic [1:0]        evt_q;
  logic [LO_W-1:0]   load_q;
  logic [LO_W-1:0]   match_q;
  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  pmatch_q;
  logic              mask_q;
  logic              mode_ok;
  logic [DW-1:0]     ctrl_rd;
  reg_addr_e         a;

  assign a = reg_addr_e'(addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      ie_q     <= 1'b0;
      en_q     <= 1'b0;
      lvl_q    <= 1'b0;
      evt_q    <= '0;
      load_q   <= '0;
      match_q  <= '0;
      pre_q    <= '0;
      pmatch_q <= '0;
      mask_q   <= 1'b0;
    end else if (wr_en) begin
      case (a)
        A_MODE: begin
          if (!en_q) begin
            mode_q <= wdata[MODE_W-1:0];
            ie_q   <= wdata[IE_BIT];
          end
        end
        A_CTRL: begin
          en_q  <= wdata[EN_BIT];
          evt_q <= wdata[EVT_LSB +: 2];
          lvl_q <= wdata[LVL_BIT];
        end
        A_LOAD:   load_q   <= wdata[LO_W-1:0];
        A_MATCH:  match_q  <= wdata[LO_W-1:0];
        A_PRE:    pre_q    <= wdata[PRE_W-1:0];
        A_PMATCH: pmatch_q <= wdata[PRE_W-1:0];
        A_MASK:   mask_q   <= wdata[0];
        default: ;
      endcase
    end
  end

  assign mode_ok = mode_q[3] && !mode_q[2] && (mode_q[1:0] == MODE_PERIODIC);

  always_comb begin
    ctrl_rd             = '0;
    ctrl_rd[EN_BIT]     = en_q;
    ctrl_rd[EVT_LSB+:2] = evt_q;
    ctrl_rd[LVL_BIT]    = lvl_q;
  end

  always_comb begin
    rdata = '0;
    case (a)
      A_MODE: begin
        rdata[MODE_W-1:0] = mode_q;
        rdata[IE_BIT]     = ie_q;
      end
      A_CTRL:   rdata = ctrl_rd;
      A_LOAD:   rdata[LO_W-1:0]  = load_q;
      A_MATCH:  rdata[LO_W-1:0]  = match_q;
      A_PRE:    rdata[PRE_W-1:0] = pre_q;
      A_PMATCH: rdata[PRE_W-1:0] = pmatch_q;
      A_MASK:   rdata[0] = mask_q;
      A_STAT:   rdata[0] = stat;
      default:  rdata = '0;
    endcase
  end

  assign stat_clr   = wr_en && (a == A_STAT) && wdata[0];
  assign cfg.period = {pre_q, load_q};
  assign cfg.match  = {pmatch_q, match_q};
  assign cfg.run    = en_q && mode_ok;
  assign cfg.invert = lvl_q;
  assign cfg.evt    = evt_sel_e'(evt_q);
  assign cfg.ie     = ie_q;
  assign cfg.mask   = mask_q;

  // R12
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wr_en && a == A_MODE) |=> ($stable(mode_q) && $stable(ie_q)))
    else $error("mode register changed while enabled");

endmodule

// File: rtl/pwm24_counter.sv
module pwm24_counter
  import pwm24_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] match,
  output logic             raw
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             reload;

  assign reload = (cnt_q == '0);
  assign cnt_nx = reload ? period : cnt_q - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      raw   <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      if (reload)
        raw <= 1'b1;
      else if (cnt_nx == match)
        raw <= 1'b0;
    end
  end

  // R4
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0 && !raw))
    else $error("counter moved while stopped");

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)))
    else $error("counter skipped a step");

  // R2
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q == '0) |=> (raw && cnt_q == $past(period)))
    else $error("reload value or level wrong");

  // R3
  low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q != '0 && (cnt_q - CNT_W'(1)) == match) |=> !raw)
    else $error("waveform not low at threshold");

endmodule

// File: rtl/pwm24_evt.sv
module pwm24_evt
  import pwm24_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     raw,
  input  evt_sel_e evt,
  input  logic     ie,
  input  logic     mask,
  input  logic     clr,
  output logic     stat,
  output logic     irq
);
  logic raw_d;
  logic rise;
  logic fall;
  logic hit;
  logic set;

  assign rise = raw && !raw_d;
  assign fall = !raw && raw_d;

  always_comb begin
    case (evt)
      EV_POS:  hit = rise;
      EV_NEG:  hit = fall;
      EV_BOTH: hit = rise || fall;
      default: hit = 1'b0;
    endcase
  end

  assign set = run && ie && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_d <= 1'b0;
      stat  <= 1'b0;
    end else begin
      raw_d <= raw;
      stat  <= set || (stat && !clr);
    end
  end

  assign irq = stat && mask;

  // R11
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat && !clr) |=> stat)
    else $error("event flag dropped without clear");

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !stat)
    else $error("event flag survived clear");

  // R10
  noie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie && !stat) |=> !stat)
    else $error("event flag set with interrupt enable off");

  // R9
  none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == EV_NONE && !stat) |=> !stat)
    else $error("event flag set by reserved code");

endmodule

// File: rtl/pwm24_timer.sv
module pwm24_timer
  import pwm24_pkg::*;
#(
  parameter int CHANNEL = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        pwm_out,
  output logic        irq
);
  chan_cfg_t cfg;
  logic      stat;
  logic      stat_clr;
  logic      raw;

  pwm24_regs #(.CHANNEL(CHANNEL)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .stat     (stat),
    .rdata    (reg_rdata),
    .cfg      (cfg),
    .stat_clr (stat_clr)
  );

  pwm24_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (cfg.run),
    .period (cfg.period),
    .match  (cfg.match),
    .raw    (raw)
  );

  pwm24_evt u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (cfg.run),
    .raw   (raw),
    .evt   (cfg.evt),
    .ie    (cfg.ie),
    .mask  (cfg.mask),
    .clr   (stat_clr),
    .stat  (stat),
    .irq   (irq)
  );

  assign pwm_out = raw ^ cfg.invert;

endmodule

// File: tb/sim_pwm24_timer.sv
`timescale 1ns/1ps
module sim_pwm24_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pwm_out;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic  lvl;
    string tag;
  } exp_t;

  exp_t q[$];
  bit   mon_arm = 1'b0;

  always #2.5 clk = ~clk;

  pwm24_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // monitor: compares pin against the scoreboard once per cycle
  always @(negedge clk) begin
    exp_t e;
    if (mon_arm) begin
      if (q.size() > 0) begin
        e = q.pop_front();
        check(e.tag, {31'b0, pwm_out}, {31'b0, e.lvl});
      end
      if (q.size() == 0) mon_arm = 1'b0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input bit arm = 1'b0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (arm) mon_arm = 1'b1;
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd_now(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_lvl(input logic lvl, input int n, input string tag);
    exp_t e;
    e.lvl = lvl; e.tag = tag;
    for (int i = 0; i < n; i++) q.push_back(e);
  endtask

  task automatic push_period(input logic inv, input int p, input int m, input string tag);
    if (m >= p) push_lvl(~inv, p + 1, tag);
    else begin
      push_lvl(~inv, p - m, tag);
      push_lvl(inv, m + 1, tag);
    end
  endtask

  task automatic setup(input logic [15:0] mode, input int p, input int m, input logic mask);
    wr(3'd1, 16'h0000);
    wr(3'd7, 16'h0001);
    wr(3'd0, mode);
    wr(3'd2, p[15:0]);
    wr(3'd4, {8'h00, p[23:16]});
    wr(3'd3, m[15:0]);
    wr(3'd5, {8'h00, m[23:16]});
    wr(3'd6, {15'b0, mask});
  endtask

  task automatic run_queue(input logic [15:0] ctrl);
    wr(3'd1, ctrl, 1'b1);
    wait (mon_arm == 1'b0);
    @(negedge clk);
  endtask

  function automatic logic [15:0] ctl(input logic inv, input logic [1:0] code);
    return 16'h0001 | (16'(code) << 2) | (16'(inv) << 6);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [15:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 pwm_out", {31'b0, pwm_out}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    for (int i = 0; i < 8; i++) begin
      rd_now(3'(i), d);
      check("R1 reg", {16'b0, d}, 0);
    end

    // R13 read-back and unimplemented bits
    wr(3'd0, 16'hFFFF); @(negedge clk); rd_now(3'd0, d); check("R13 mode", {16'b0, d}, 32'h020F);
    wr(3'd1, 16'hFF48); @(negedge clk); rd_now(3'd1, d); check("R13 ctrl", {16'b0, d}, 32'h0048);
    wr(3'd2, 16'hBEEF); @(negedge clk); rd_now(3'd2, d); check("R13 load", {16'b0, d}, 32'hBEEF);
    wr(3'd3, 16'h1234); @(negedge clk); rd_now(3'd3, d); check("R13 match", {16'b0, d}, 32'h1234);
    wr(3'd4, 16'hFFA5); @(negedge clk); rd_now(3'd4, d); check("R13 pre", {16'b0, d}, 32'h00A5);
    wr(3'd5, 16'hFF5A); @(negedge clk); rd_now(3'd5, d); check("R13 pmatch", {16'b0, d}, 32'h005A);
    wr(3'd6, 16'hFFFF); @(negedge clk); rd_now(3'd6, d); check("R13 mask", {16'b0, d}, 32'h0001);

    // R2 R3 basic waveform
    setup(16'h000A, 9, 3, 1'b0);
    push_lvl(1'b0, 1, "R2 idle");
    for (int i = 0; i < 3; i++) push_period(1'b0, 9, 3, "R3 basic");
    run_queue(ctl(1'b0, 2'd2));

    // R5 inverted output
    setup(16'h000A, 5, 1, 1'b0);
    push_lvl(1'b1, 1, "R5 idle");
    for (int i = 0; i < 3; i++) push_period(1'b1, 5, 1, "R5 inverted");
    run_queue(ctl(1'b1, 2'd2));

    // R3 threshold at or above period
    setup(16'h000A, 4, 4, 1'b0);
    push_lvl(1'b0, 1, "R3 idle");
    push_lvl(1'b1, 12, "R3 full high");
    run_queue(ctl(1'b0, 2'd2));

    // R7 match rewritten mid-period
    setup(16'h000A, 9, 3, 1'b0);
    push_lvl(1'b0, 1, "R7 idle");
    push_lvl(1'b1, 10, "R7 first period");
    push_period(1'b0, 9, 6, "R7 new match");
    push_period(1'b0, 9, 6, "R7 new match");
    wr(3'd1, ctl(1'b0, 2'd2), 1'b1);
    repeat (5) @(posedge clk);
    wr(3'd3, 16'd6);
    wait (mon_arm == 1'b0);
    @(negedge clk);

    // R6 load rewritten mid-period
    setup(16'h000A, 9, 3, 1'b0);
    push_lvl(1'b0, 1, "R6 idle");
    push_period(1'b0, 9, 3, "R6 old period");
    push_period(1'b0, 5, 3, "R6 new period");
    push_period(1'b0, 5, 3, "R6 new period");
    wr(3'd1, ctl(1'b0, 2'd2), 1'b1);
    repeat (5) @(posedge clk);
    wr(3'd2, 16'd5);
    wait (mon_arm == 1'b0);
    @(negedge clk);

    // R12 mode write ignored while enabled
    setup(16'h000A, 9, 3, 1'b0);
    push_lvl(1'b0, 1, "R12 idle");
    push_period(1'b0, 9, 3, "R12 keeps running");
    push_period(1'b0, 9, 3, "R12 keeps running");
    wr(3'd1, ctl(1'b0, 2'd2), 1'b1);
    repeat (3) @(posedge clk);
    wr(3'd0, 16'h0000);
    wait (mon_arm == 1'b0);
    @(negedge clk);
    rd_now(3'd0, d);
    check("R12 mode readback", {16'b0, d}, 32'h000A);

    // R4 non-PWM modes hold the output idle
    setup(16'h0009, 4, 1, 1'b0);
    push_lvl(1'b0, 21, "R4 one-shot field");
    run_queue(ctl(1'b0, 2'd2));
    setup(16'h000E, 4, 1, 1'b0);
    push_lvl(1'b0, 21, "R4 capture bit set");
    run_queue(ctl(1'b0, 2'd2));

    // R2 full 24-bit period and threshold
    setup(16'h000A, 32'h010004, 32'h010001, 1'b0);
    push_lvl(1'b0, 1, "R2 idle");
    push_period(1'b0, 32'h010004, 32'h010001, "R2 24-bit");
    push_lvl(1'b1, 3, "R2 24-bit reload");
    run_queue(ctl(1'b0, 2'd2));

    // R8 edge selection, with and without inversion
    for (int c = 0; c < 6; c++) begin
      logic       inv;
      logic [1:0] code;
      logic       early;
      inv   = (c % 2) == 1;
      code  = (c < 2) ? 2'd0 : (c < 4) ? 2'd1 : 2'd3;
      early = (code != 2'd1);
      setup(16'h020A, 20, 10, 1'b1);
      wr(3'd1, ctl(inv, code));
      wait_neg(3);
      rd_now(3'd7, d);
      check($sformatf("R8 early inv=%0d code=%0d", inv, code), {16'b0, d}, {31'b0, early});
      check($sformatf("R8 irq early inv=%0d code=%0d", inv, code), {31'b0, irq}, {31'b0, early});
      wait_neg(9);
      rd_now(3'd7, d);
      check($sformatf("R8 late inv=%0d code=%0d", inv, code), {16'b0, d}, 1);
    end

    // R9 reserved code
    setup(16'h020A, 20, 10, 1'b1);
    wr(3'd1, ctl(1'b0, 2'd2));
    wait_neg(30);
    rd_now(3'd7, d);
    check("R9 reserved code", {16'b0, d}, 0);
    check("R9 irq", {31'b0, irq}, 0);

    // R10 interrupt enable off, then mask off
    setup(16'h000A, 20, 10, 1'b1);
    wr(3'd1, ctl(1'b0, 2'd3));
    wait_neg(30);
    rd_now(3'd7, d);
    check("R10 no ie", {16'b0, d}, 0);
    setup(16'h020A, 20, 10, 1'b0);
    wr(3'd1, ctl(1'b0, 2'd0));
    wait_neg(3);
    rd_now(3'd7, d);
    check("R10 flag with mask off", {16'b0, d}, 1);
    check("R10 irq masked", {31'b0, irq}, 0);

    // R11 sticky and write-one-to-clear
    setup(16'h020A, 20, 10, 1'b1);
    wr(3'd1, ctl(1'b0, 2'd0));
    wait_neg(3);
    rd_now(3'd7, d);
    check("R11 set", {16'b0, d}, 1);
    wr(3'd7, 16'h0001);
    @(negedge clk);
    rd_now(3'd7, d);
    check("R11 cleared", {16'b0, d}, 0);
    check("R11 irq cleared", {31'b0, irq}, 0);
    wait_neg(20);
    rd_now(3'd7, d);
    check("R11 set again", {16'b0, d}, 1);
    wr(3'd7, 16'h0000);
    wait_neg(12);
    rd_now(3'd7, d);
    check("R11 sticky", {16'b0, d}, 1);
    check("R11 irq sticky", {31'b0, irq}, 1);

    report();
  end
endmodule